// File: doc/BRIEF.md
# High-Time Pulse Capture Timer

This block measures how long a digital input stays high. A free-running up-counter advances once per prescaled tick. It counts from zero to a programmable reload value, then wraps to zero. The block waits for a qualifying rising edge on the input. At that edge it stores the counter, clears the counter and the tick divider, and then watches for a falling edge. Every counter wrap while the input is high adds one to a wrap count. At the falling edge it stores the counter again and forms the total length in ticks. It then holds the result with a done level until that level is cleared.

An edge divider can make only every 2nd, 4th or 8th qualifying edge start a capture. Two one-clock interrupt pulses, each with its own enable, mark captures and counter wraps. While the run input is low, counting is frozen and edges are ignored.

Top module: `pulse_hightime_timer`

## Requirements
- R1: After reset, cap_val, wrap_cnt and total are 0, and done, wrap_sat, cap_irq and upd_irq are low.
- R2: While run is high, the counter advances once every tick_div+1 clocks. When it advances from the value period, it goes to 0 instead, and that wrap drives upd_irq high for the following clock if upd_ie is set.
- R3: A capture fires in the edge-handling clock. A level change on sig_in in place before clock edge k is handled at edge k+2. An armed rising capture stores the counter in cap_val, sets the counter and tick divider to 0, clears wrap_cnt and wrap_sat, and arms for a falling edge.
- R4: A falling capture stores the counter in cap_val and sets total = wrap_cnt*(period+1) + cap_val, truncated to 32 bits. It also raises done.
- R5: edge_div selects the divider: 0 → every qualifying edge, 1 → every 2nd, 2 → every 4th, 3 → every 8th. Edge counting restarts after each capture and while a result is held.
- R6: cap_irq is high for one clock after each capture (rising or falling) only if cap_ie is set. upd_irq obeys upd_ie in the same way.
- R7: A wrap that finds wrap_cnt at 65535 while waiting for the falling edge leaves wrap_cnt unchanged and sets wrap_sat. wrap_sat stays set until the next rising capture.
- R8: done stays high and the result stays unchanged until done_clr is high in a clock. Input edges are ignored while done is high. After done_clr the block arms for a rising edge.
- R9: A wrap in the same clock as the falling capture is added to wrap_cnt (and to total) only when the captured value is 0.
- R10: While run is low, the counter and the tick divider hold, and no capture fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 1 | Measured signal (asynchronous) |
| run | input | 1 | Counting and capture enable |
| tick_div | input | 16 | Tick divider value; ratio is tick_div+1 |
| period | input | 16 | Counter reload (top) value |
| edge_div | input | 2 | Edge divider select |
| cap_ie | input | 1 | Capture interrupt enable |
| upd_ie | input | 1 | Wrap interrupt enable |
| done_clr | input | 1 | Releases a held result and rearms |
| cap_val | output | 16 | Last captured counter value |
| wrap_cnt | output | 16 | Wraps counted during the high time |
| total | output | 32 | High time in ticks |
| done | output | 1 | Result held |
| wrap_sat | output | 1 | Wrap count saturated |
| cap_irq | output | 1 | Capture interrupt pulse |
| upd_irq | output | 1 | Wrap interrupt pulse |

## Verification
A sig_in change reaches the capture outputs two clock edges after the edge that first samples it. cap_irq follows one edge after the capture, and upd_irq follows one edge after the wrap. The bench's behavioural model carries the input through a two-sample history. It also registers each interrupt one step late, so every output is compared at the falling clock edge in exactly the clock it is due. Each scenario is tagged with the requirement it targets. The scenarios are long pulses over many wraps, a reload of zero that puts wraps and captures in the same clock, edge division, saturation after 65536 wraps, a frozen run, and edges that arrive while a result is held.

// File: rtl/pulse_hightime_timer.sv
module pulse_hightime_timer #(
  parameter int CW = 16,
  parameter int NW = 16,
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sig_in,
  input  logic          run,
  input  logic [CW-1:0] tick_div,
  input  logic [CW-1:0] period,
  input  logic [1:0]    edge_div,
  input  logic          cap_ie,
  input  logic          upd_ie,
  input  logic          done_clr,
  output logic [CW-1:0] cap_val,
  output logic [NW-1:0] wrap_cnt,
  output logic [TW-1:0] total,
  output logic          done,
  output logic          wrap_sat,
  output logic          cap_irq,
  output logic          upd_irq
);
  typedef enum logic [1:0] {ARMED, HIGH, HELD} st_t;

  st_t st_q;
  logic [2:0] smp_q;
  logic [CW-1:0] pcnt_q, cnt_q;
  logic [2:0] ecnt_q;
  logic [NW-1:0] n_q;

  logic rise, fall, tick, wrap, qual, go, n_max, bump;
  logic [2:0] need;
  logic [CW:0] span;
  logic [NW-1:0] n_eff;

  assign rise  = smp_q[1] & ~smp_q[2];
  assign fall  = ~smp_q[1] & smp_q[2];
  assign tick  = run && (pcnt_q >= tick_div);
  assign wrap  = tick && (cnt_q == period);
  assign qual  = run && ((st_q == ARMED && rise) || (st_q == HIGH && fall));
  assign need  = 3'((4'd1 << edge_div) - 4'd1);
  assign go    = qual && (ecnt_q >= need);
  assign n_max = &n_q;
  assign bump  = wrap && (cnt_q == '0);
  assign n_eff = n_q + NW'(bump && !n_max);
  assign span  = {1'b0, period} + (CW+1)'(1);
  assign done  = (st_q == HELD);
  assign wrap_cnt = n_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) smp_q <= '0;
    else        smp_q <= {smp_q[1:0], sig_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pcnt_q <= '0;
      cnt_q  <= '0;
    end else if (go && st_q == ARMED) begin
      pcnt_q <= '0;
      cnt_q  <= '0;
    end else if (tick) begin
      pcnt_q <= '0;
      cnt_q  <= wrap ? '0 : cnt_q + 1'b1;
    end else if (run) begin
      pcnt_q <= pcnt_q + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    ecnt_q <= '0;
    else if (go || st_q == HELD)   ecnt_q <= '0;
    else if (qual)                 ecnt_q <= ecnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q     <= ARMED;
      n_q      <= '0;
      wrap_sat <= 1'b0;
      cap_val  <= '0;
      total    <= '0;
    end else begin
      if (go) cap_val <= cnt_q;
      case (st_q)
        ARMED: if (go) begin
          st_q     <= HIGH;
          n_q      <= '0;
          wrap_sat <= 1'b0;
        end
        HIGH: if (go) begin
          st_q  <= HELD;
          n_q   <= n_eff;
          total <= TW'(n_eff) * TW'(span) + TW'(cnt_q);
          if (bump && n_max) wrap_sat <= 1'b1;
        end else if (wrap) begin
          if (n_max) wrap_sat <= 1'b1;
          else       n_q <= n_q + 1'b1;
        end
        default: if (done_clr) st_q <= ARMED;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cap_irq <= 1'b0;
      upd_irq <= 1'b0;
    end else begin
      cap_irq <= go && cap_ie;
      upd_irq <= wrap && upd_ie;
    end

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_clr) |=> (done && $stable(total) && $stable(cap_val)));
  // R6
  cap_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_irq |-> $past(cap_ie));
  // R6
  upd_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_irq |-> $past(upd_ie));
  // R10
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(cnt_q) && $stable(pcnt_q)));
  // R7
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_sat && st_q == HIGH) |=> $stable(wrap_cnt));
  // R4
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(st_q == HIGH));
endmodule

// File: tb/sim_pulse_hightime_timer.sv
module sim_pulse_hightime_timer;
  logic clk = 0, rst_n = 0, sig_in = 0, run = 0;
  logic [15:0] tick_div = 0, period = 0;
  logic [1:0] edge_div = 0;
  logic cap_ie = 0, upd_ie = 0, done_clr = 0;
  logic [15:0] cap_val, wrap_cnt;
  logic [31:0] total;
  logic done, wrap_sat, cap_irq, upd_irq;

  int checks = 0, errors = 0, cycles = 0;
  string phase = "R1";
  bit finished = 0;

  always #2.5 clk = ~clk;

  pulse_hightime_timer u0 (.*);

  // behavioural reference
  int m_h1, m_h2, m_h0, m_p, m_c, m_n, m_st, m_e, m_cap;
  bit m_sat, m_ci, m_ui;
  longint m_tot;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_h0 = 0; m_h1 = 0; m_h2 = 0; m_p = 0; m_c = 0; m_n = 0; m_st = 0;
      m_e = 0; m_cap = 0; m_sat = 0; m_ci = 0; m_ui = 0; m_tot = 0;
    end else begin
      bit r, f, tk, wr, q, go;
      int oc, ost, need;
      r = (m_h1 == 1) && (m_h2 == 0);
      f = (m_h1 == 0) && (m_h2 == 1);
      tk = run && (m_p >= tick_div);
      wr = tk && (m_c == period);
      q = run && ((m_st == 0 && r) || (m_st == 1 && f));
      need = (1 << edge_div) - 1;
      go = q && (m_e >= need);
      oc = m_c; ost = m_st;
      m_ci = go && cap_ie;
      m_ui = wr && upd_ie;
      if (go) m_cap = oc;
      if (go && ost == 0) begin
        m_c = 0; m_p = 0; m_n = 0; m_sat = 0; m_st = 1;
      end else begin
        if (tk) begin m_p = 0; m_c = wr ? 0 : oc + 1; end
        else if (run) m_p = m_p + 1;
        if (ost == 1) begin
          if (go) begin
            if (wr && oc == 0) begin
              if (m_n == 65535) m_sat = 1; else m_n = m_n + 1;
            end
            m_tot = (longint'(m_n) * (longint'(period) + 1) + oc) & 64'hFFFF_FFFF;
            m_st = 2;
          end else if (wr) begin
            if (m_n == 65535) m_sat = 1; else m_n = m_n + 1;
          end
        end else if (ost == 2 && done_clr) m_st = 0;
      end
      if (go || ost == 2) m_e = 0;
      else if (q) m_e = m_e + 1;
      m_h2 = m_h1; m_h1 = m_h0; m_h0 = sig_in;
    end
  end

  task automatic chk(string what, longint got, longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d", phase, what, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    chk("cap_val", cap_val, m_cap);
    chk("wrap_cnt", wrap_cnt, m_n);
    chk("total", total, m_tot);
    chk("done", done, m_st == 2);
    chk("wrap_sat", wrap_sat, m_sat);
    chk("cap_irq", cap_irq, m_ci);
    chk("upd_irq", upd_irq, m_ui);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int hi, int lo);
    sig_in = 1; wait_n(hi);
    sig_in = 0; wait_n(lo);
  endtask

  task automatic release_done();
    done_clr = 1; wait_n(1); done_clr = 0; wait_n(2);
  endtask

  initial begin
    wait_n(3);
    // R1 reset values at the ports
    chk("reset cap_val", cap_val, 0);
    chk("reset total", total, 0);
    chk("reset done", done, 0);
    chk("reset irq", cap_irq | upd_irq | wrap_sat, 0);
    rst_n = 1;
    wait_n(2);

    phase = "R2"; tick_div = 1; period = 9; cap_ie = 1; upd_ie = 1; run = 1;
    wait_n(60);
    phase = "R3"; pulse(5, 10);
    chk("R4 done after short pulse", done, 1);
    release_done();
    phase = "R4"; pulse(97, 10);
    chk("R4 wraps counted", wrap_cnt > 0, 1);
    release_done();

    phase = "R6"; cap_ie = 0; upd_ie = 0; pulse(43, 10);
    chk("R6 cap_irq masked", cap_irq, 0);
    release_done(); cap_ie = 1; upd_ie = 1;

    phase = "R8"; sig_in = 1; wait_n(20); sig_in = 0; wait_n(5);
    pulse(7, 7); pulse(9, 9);
    chk("R8 result held", done, 1);
    release_done();

    phase = "R5";
    for (int d = 1; d < 4; d++) begin
      edge_div = d[1:0];
      for (int k = 0; k < 20; k++) pulse(6 + k, 5);
      if (done) release_done();
    end
    edge_div = 0;

    phase = "R9"; tick_div = 0; period = 0;
    pulse(13, 6); release_done();
    tick_div = 2; period = 3;
    for (int k = 0; k < 12; k++) begin pulse(20 + k, 8); release_done(); end

    phase = "R10"; run = 0; pulse(15, 10); wait_n(20);
    chk("R10 no capture while frozen", done, 0);
    run = 1; wait_n(10);

    phase = "R7"; tick_div = 0; period = 0;
    pulse(66000, 10);
    chk("R7 saturated", wrap_sat, 1);
    chk("R7 count pinned", wrap_cnt, 65535);
    release_done();
    pulse(10, 10);
    chk("R7 sat cleared by new rise", wrap_sat, 0);
    release_done();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule